// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from system memory to a MAC transmit port. Software builds a circular chain of descriptors in memory. Each one names a frame buffer and a byte count, and each links to its successor through an explicit pointer. Software hands a descriptor to the engine by setting its owner flag, then writes the demand command. The engine reads the descriptor, pulls the buffer a 32-bit word at a time through a request/grant memory port, and emits it as a byte stream. When the frame is done, it writes the status word back with the owner flag cleared.

After each write-back the engine follows the next pointer and keeps going while it finds descriptors it owns. When it meets one the host still owns, it stops and issues no further memory traffic until a new demand arrives. A demand that arrives while the engine is busy is remembered. When the engine would otherwise go to sleep, it re-reads the current descriptor instead.

Malformed descriptors are not sent. They get an error status instead. Completions that request it, and all errors, raise a sticky interrupt cause that software clears by writing ones.

Top module: `txring_dma`

## Requirements
- R1: While and directly after reset the engine makes no memory request, `tx_valid` is 0, and `irq` and `irq_cause` are 0.
- R2: A demand that finds the current descriptor's status bit 31 at 0 causes exactly one memory read (the status word), after which the engine makes no request until another demand.
- R3: A descriptor occupies four words at byte offsets +0 status, +4 control, +8 buffer address, +12 next pointer. The owner flag is status bit 31, and the byte count is control bits [10:0]. The buffer address low two bits and the next pointer low four bits are treated as 0. A request holds its address until granted.
- R4: A well-formed frame sends exactly its byte count of bytes from the buffer in ascending address order, least significant byte of each word first. `tx_last` is 1 on the final byte only, and `tx_valid` is 0 in the cycle after the last byte is accepted.
- R5: The status write to the descriptor's +0 word is the final memory access for that descriptor. For a sent frame it writes the value 0x00000000, which clears the owner flag.
- R6: A descriptor whose byte count is 0, or whose control word lacks bit 21 (first) or bit 22 (last), sends no bytes and gets status 0x00008100 (bit 15 error, bit 8 abort).
- R7: `irq_cause` bit 0 is set when a sent frame had control bit 23 set, and bit 1 is set on an R6 error. `irq` is the OR of both bits. Writing register 2 clears the cause bits that are 1 in data bits [1:0].
- R8: After a write-back the engine moves to the next pointer and keeps sending while the owner flag is set, so one demand can send several frames.
- R9: A demand (register 1, data bit 0 = 1) written while the engine is busy makes it re-read the current descriptor once it would otherwise go idle.
- R10: Writing register 0 while idle sets the current descriptor address. The same write while a frame is in flight has no effect.
- R11: `tx_nocrc` equals control bit 16 of the descriptor being sent.
- R12: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index: 0 ring base, 1 command, 2 interrupt clear |
| reg_wdata | input | 32 | Register write data |
| irq_cause | output | 2 | Sticky causes: bit 0 completion, bit 1 error |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| tx_nocrc | output | 1 | Frame asks for no CRC append |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
Several properties are checked on every cycle. The write-back always clears the owner flag and lands on a 16-byte boundary. Reads are word aligned, and a request keeps its address until granted. The byte stream holds still under back-pressure and drops valid right after the last byte. Every rise of `irq` is traced to a completion or error event. Only the bench scenarios can show the rest. These are the byte order and count, the error status of malformed descriptors, chain walking across several descriptors, the sleep with a single status read, the remembered demand, and that a base write during a frame is ignored.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int CNT_W      = $clog2(WORD_BYTES) + 1;

    // descriptor bit positions
    localparam int OWN_BIT   = 31;
    localparam int ERR_BIT   = 15;
    localparam int ABT_BIT   = 8;
    localparam int FIRST_BIT = 21;
    localparam int LAST_BIT  = 22;
    localparam int IRQ_BIT   = 23;
    localparam int NOCRC_BIT = 16;

    // register indices
    localparam int REG_RING = 0;
    localparam int REG_CMD  = 1;
    localparam int REG_ICLR = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STAT,
        S_RD_CTRL,
        S_RD_BUF,
        S_RD_NEXT,
        S_RD_DATA,
        S_SEND,
        S_WB
    } state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              ev_done,
    input  logic              ev_err,
    output logic              base_we,
    output logic [ADDR_W-1:0] base_val,
    output logic              kick,
    output logic [1:0]        cause,
    output logic              irq
);
    typedef struct packed {
        logic [1:0] cause;
    } regs_s;

    regs_s q, d;

    always_comb begin
        d        = q;
        base_we  = reg_we && (reg_addr == REG_AW'(REG_RING));
        base_val = reg_wdata[ADDR_W-1:0] & ~ADDR_W'(15);
        kick     = reg_we && (reg_addr == REG_AW'(REG_CMD)) && reg_wdata[0];
        if (reg_we && (reg_addr == REG_AW'(REG_ICLR)))
            d.cause = q.cause & ~reg_wdata[1:0];
        // new events win over a clear in the same cycle
        if (ev_done) d.cause[0] = 1'b1;
        if (ev_err)  d.cause[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cause = q.cause;
    assign irq   = |q.cause;
endmodule

// File: rtl/txr_pack.sv
module txr_pack
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              last,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              busy
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              last;
    } pack_s;

    pack_s q, d;

    always_comb begin
        d = q;
        if (q.cnt != '0 && tx_ready) begin
            d.word = q.word >> 8;
            d.cnt  = q.cnt - CNT_W'(1);
        end
        // the sequencer only loads when the holding register is empty
        if (load) begin
            d.word = word;
            d.cnt  = nbytes;
            d.last = last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid = (q.cnt != '0);
    assign tx_data  = q.word[7:0];
    assign tx_last  = q.last && (q.cnt == CNT_W'(1));
    assign busy     = (q.cnt != '0);
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              pk_busy,
    output logic              pk_load,
    output logic [CNT_W-1:0]  pk_n,
    output logic              pk_last,
    output logic              ev_done,
    output logic              ev_err,
    output logic              nocrc
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_NEXT = ADDR_W'(12);
    localparam logic [LEN_W-1:0]  WB_LEN   = LEN_W'(WORD_BYTES);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] bptr;
        logic [ADDR_W-1:0] nxt;
        logic [WORD_W-1:0] ctrl;
        logic [LEN_W-1:0]  remain;
        logic              pend;
        logic              err;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cur;
        mem_wdata = '0;
        pk_load   = 1'b0;
        pk_n      = '0;
        pk_last   = 1'b0;
        ev_done   = 1'b0;
        ev_err    = 1'b0;

        if (kick && q.st != S_IDLE) d.pend = 1'b1;

        unique case (q.st)
            S_IDLE: begin
                if (base_we) d.cur = base_val;
                if (kick || q.pend) begin
                    d.st   = S_RD_STAT;
                    d.pend = 1'b0;
                end
            end
            S_RD_STAT: begin
                mem_req = 1'b1;
                if (mem_gnt) d.st = mem_rdata[OWN_BIT] ? S_RD_CTRL : S_IDLE;
            end
            S_RD_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + OFS_CTRL;
                if (mem_gnt) begin
                    d.ctrl   = mem_rdata;
                    d.remain = mem_rdata[LEN_W-1:0];
                    d.st     = S_RD_BUF;
                end
            end
            S_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + OFS_BUF;
                if (mem_gnt) begin
                    d.bptr = mem_rdata[ADDR_W-1:0] & ~ADDR_W'(3);
                    d.st   = S_RD_NEXT;
                end
            end
            S_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + OFS_NEXT;
                if (mem_gnt) begin
                    d.nxt = mem_rdata[ADDR_W-1:0] & ~ADDR_W'(15);
                    if (q.remain == '0 || !q.ctrl[FIRST_BIT] || !q.ctrl[LAST_BIT]) begin
                        d.err = 1'b1;
                        d.st  = S_WB;
                    end else begin
                        d.err = 1'b0;
                        d.st  = S_RD_DATA;
                    end
                end
            end
            S_RD_DATA: begin
                mem_req  = !pk_busy;
                mem_addr = q.bptr;
                if (!pk_busy && mem_gnt) begin
                    pk_load = 1'b1;
                    d.bptr  = q.bptr + ADDR_W'(WORD_BYTES);
                    if (q.remain > WB_LEN) begin
                        pk_n     = CNT_W'(WORD_BYTES);
                        d.remain = q.remain - WB_LEN;
                    end else begin
                        pk_n     = q.remain[CNT_W-1:0];
                        pk_last  = 1'b1;
                        d.remain = '0;
                        d.st     = S_SEND;
                    end
                end
            end
            S_SEND: begin
                if (!pk_busy) d.st = S_WB;
            end
            S_WB: begin
                mem_req            = 1'b1;
                mem_we             = 1'b1;
                mem_wdata[ERR_BIT] = q.err;
                mem_wdata[ABT_BIT] = q.err;
                if (mem_gnt) begin
                    ev_done = !q.err && q.ctrl[IRQ_BIT];
                    ev_err  = q.err;
                    d.cur   = q.nxt;
                    d.st    = S_RD_STAT;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign nocrc = q.ctrl[NOCRC_BIT];
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [1:0]        irq_cause,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_nocrc,
    input  logic              tx_ready
);
    logic              base_we;
    logic [ADDR_W-1:0] base_val;
    logic              kick;
    logic              ev_done;
    logic              ev_err;
    logic              pk_busy;
    logic              pk_load;
    logic [CNT_W-1:0]  pk_n;
    logic              pk_last;

    txr_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .ev_done  (ev_done),
        .ev_err   (ev_err),
        .base_we  (base_we),
        .base_val (base_val),
        .kick     (kick),
        .cause    (irq_cause),
        .irq      (irq)
    );

    txr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (kick),
        .base_we  (base_we),
        .base_val (base_val),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_gnt  (mem_gnt),
        .mem_rdata(mem_rdata),
        .pk_busy  (pk_busy),
        .pk_load  (pk_load),
        .pk_n     (pk_n),
        .pk_last  (pk_last),
        .ev_done  (ev_done),
        .ev_err   (ev_err),
        .nocrc    (tx_nocrc)
    );

    txr_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pk_load),
        .word    (mem_rdata),
        .nbytes  (pk_n),
        .last    (pk_last),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_last (tx_last),
        .busy    (pk_busy)
    );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic              ev_done,
    input logic              ev_err
);
    assert_wb_owner_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    assert_wb_on_desc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[3:0] == 4'h0);

    assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr[1:0] == 2'b00);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_stream_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_gap_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid);

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_done || ev_err));
endmodule

bind txring_dma txr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .tx_data  (tx_data),
    .irq      (irq),
    .ev_done  (ev_done),
    .ev_err   (ev_err)
);

// File: tb/sim_txring_dma.sv
module sim_txring_dma;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  irq_cause;
    logic        irq;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_nocrc, tx_ready;
    logic [7:0]  tx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    txring_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_cause(irq_cause), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_nocrc(tx_nocrc), .tx_ready(tx_ready)
    );

    // memory model and stream sink
    logic [31:0] mem [0:255];
    logic [2:0]  wcnt = '0;
    int          lat = 0;
    logic        poke_en = 1'b0;
    logic [31:0] poke_addr = '0, poke_data = '0;
    int          gnt_cnt = 0;
    logic [7:0]  rxb [0:511];
    int          rx_n = 0, last_cnt = 0, last_idx = 0;
    logic        nocrc_seen = 1'b0;
    logic        ready_en = 1'b1, tgl = 1'b0, tgl_q = 1'b0;

    assign mem_gnt   = mem_req && (int'(wcnt) >= lat);
    assign mem_rdata = mem[mem_addr[9:2]];
    assign tx_ready  = ready_en && (!tgl || tgl_q);

    always @(posedge clk) begin
        tgl_q <= ~tgl_q;
        if (mem_req && !mem_gnt) wcnt <= wcnt + 3'd1;
        else                     wcnt <= '0;
        if (mem_req && mem_gnt) gnt_cnt <= gnt_cnt + 1;
        if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (poke_en) mem[poke_addr[9:2]] <= poke_data;
        if (tx_valid && tx_ready) begin
            rxb[rx_n[8:0]] <= tx_data;
            rx_n <= rx_n + 1;
            nocrc_seen <= tx_nocrc;
            if (tx_last) begin
                last_cnt <= last_cnt + 1;
                last_idx <= rx_n;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic regw(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // descriptor fields only; status word written separately
    task automatic build(input int slot, input int len, input logic [7:0] seed, input logic [31:0] flags);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] word;
            for (int b = 0; b < 4; b++) word[b*8 +: 8] = seed + 8'(w*4 + b);
            poke(32'h100 + 32'(slot*64 + w*4), word);
        end
        poke(32'(slot*16 + 4), flags | 32'(len));
        poke(32'(slot*16 + 8), 32'h100 + 32'(slot*64));
        poke(32'(slot*16 + 12), 32'(((slot + 1) % 4) * 16));
    endtask

    task automatic wait_done(input int slot, input string tag);
        int t;
        t = 0;
        while (mem[slot*4][31] && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 4000, tag, mem[slot*4], 32'h0);
        repeat (12) @(negedge clk);
    endtask

    task automatic check_bytes(input int rx0, input int len, input logic [7:0] seed, input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < len; k++)
            if (rxb[rx0 + k] !== seed + 8'(k)) bad++;
        chk(bad == 0, tag, 32'(bad), 32'h0);
    endtask

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] seed;
        logic       irq;
        logic       nocrc;
        logic       first;
        logic       last;
        logic [1:0] lat;
        logic       tgl;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'd1,  8'h10, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0},
        '{8'd4,  8'h20, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1},
        '{8'd5,  8'h30, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0},
        '{8'd13, 8'h40, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
        '{8'd64, 8'h50, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0},
        '{8'd0,  8'h60, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0},
        '{8'd8,  8'h70, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1},
        '{8'd3,  8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        vec_t v;
        int   rx0, lc0, g0;
        logic [31:0] flags;
        logic        good;
        logic [1:0]  ecause;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!mem_req && !tx_valid && !irq && irq_cause == 2'b00, "R1 in reset",
            {mem_req, tx_valid, irq}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req && !tx_valid && !irq, "R1 after reset", {mem_req, tx_valid, irq}, 32'h0);

        regw(4'd0, 32'h0);   // R10: ring base at slot 0

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            lat = int'(v.lat);
            tgl = v.tgl;
            flags = (32'(v.first) << 21) | (32'(v.last) << 22) |
                    (32'(v.irq) << 23) | (32'(v.nocrc) << 16);
            good = v.first && v.last && v.len != 0;
            ecause = good ? {1'b0, v.irq} : 2'b10;
            build(i % 4, int'(v.len), v.seed, flags);
            poke(32'((i % 4) * 16), 32'h8000_0000);
            rx0 = rx_n; lc0 = last_cnt;
            regw(4'd1, 32'h1);
            wait_done(i % 4, "R5 owner cleared");
            chk(rx_n - rx0 == (good ? int'(v.len) : 0), "R4/R6 byte count",
                32'(rx_n - rx0), good ? 32'(v.len) : 32'h0);
            chk(mem[(i % 4) * 4] == (good ? 32'h0 : 32'h0000_8100), "R5/R6 status word",
                mem[(i % 4) * 4], good ? 32'h0 : 32'h0000_8100);
            chk(irq_cause == ecause && irq == (ecause != 2'b00), "R7 cause",
                {irq, irq_cause}, {ecause != 2'b00, ecause});
            if (good) begin
                check_bytes(rx0, int'(v.len), v.seed, "R4 byte order");
                chk(last_cnt == lc0 + 1 && last_idx == rx0 + int'(v.len) - 1, "R4 last marker",
                    32'(last_idx), 32'(rx0 + int'(v.len) - 1));
                chk(nocrc_seen == v.nocrc, "R11 nocrc", 32'(nocrc_seen), 32'(v.nocrc));
            end
            regw(4'd2, 32'h3);
            chk(irq_cause == 2'b00 && !irq, "R7 clear", 32'(irq_cause), 32'h0);
        end
        tgl = 1'b0;

        // R2: demand on a host-owned descriptor reads once and sleeps
        lat = 0;
        g0 = gnt_cnt;
        regw(4'd1, 32'h1);
        repeat (50) @(negedge clk);
        chk(gnt_cnt - g0 == 1, "R2 single status read", 32'(gnt_cnt - g0), 32'h1);
        chk(!mem_req, "R2 no request while asleep", 32'(mem_req), 32'h0);

        // R8: two descriptors on one demand
        build(0, 6, 8'hA0, 32'h0060_0000);
        build(1, 7, 8'hB0, 32'h00E0_0000);
        poke(32'h00, 32'h8000_0000);
        poke(32'h10, 32'h8000_0000);
        rx0 = rx_n; lc0 = last_cnt;
        regw(4'd1, 32'h1);
        wait_done(1, "R8 second descriptor done");
        chk(rx_n - rx0 == 13 && last_cnt - lc0 == 2, "R8 two frames sent",
            32'(rx_n - rx0), 32'd13);
        check_bytes(rx0, 6, 8'hA0, "R8 first frame data");
        check_bytes(rx0 + 6, 7, 8'hB0, "R8 second frame data");
        chk(irq_cause == 2'b01, "R7 cause after chain", 32'(irq_cause), 32'h1);
        regw(4'd2, 32'h3);

        // R10: relocate while idle (engine now at slot 2) to slot 3
        regw(4'd0, 32'h30);
        build(3, 5, 8'hC0, 32'h0060_0000);
        poke(32'h30, 32'h8000_0000);
        rx0 = rx_n;
        regw(4'd1, 32'h1);
        wait_done(3, "R10 relocated descriptor done");
        chk(rx_n - rx0 == 5, "R10 relocated frame length", 32'(rx_n - rx0), 32'd5);
        check_bytes(rx0, 5, 8'hC0, "R10 relocated frame data");

        // R10: base write during a frame is ignored (engine at slot 0)
        ready_en = 1'b0;
        build(0, 40, 8'hD0, 32'h0060_0000);
        poke(32'h00, 32'h8000_0000);
        rx0 = rx_n;
        regw(4'd1, 32'h1);
        repeat (30) @(negedge clk);
        regw(4'd0, 32'hC0);
        ready_en = 1'b1;
        wait_done(0, "R10 busy base write ignored");
        chk(rx_n - rx0 == 40, "R10 frame intact", 32'(rx_n - rx0), 32'd40);
        check_bytes(rx0, 40, 8'hD0, "R10 frame data intact");

        // R9: demand during the status read is remembered (engine at slot 1)
        lat = 3;
        build(1, 9, 8'hE0, 32'h0060_0000);
        poke(32'h10, 32'h0);
        rx0 = rx_n;
        regw(4'd1, 32'h1);
        regw(4'd1, 32'h1);
        while (!mem_gnt) @(negedge clk);
        @(posedge clk);
        poke(32'h10, 32'h8000_0000);
        wait_done(1, "R9 remembered demand");
        chk(rx_n - rx0 == 9, "R9 frame sent", 32'(rx_n - rx0), 32'd9);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule